// File: doc/BRIEF.md
# Operating-System Timer with Watchdog Channel

The block keeps one 32-bit up-counter that advances on each cycle where a tick-enable input is high. It compares the counter against four 32-bit match values. When the counter takes a match value and that channel is enabled, the channel is flagged in a sticky status register and on its own interrupt line. The line stays high until software clears the status bit by writing a one to it. Channel 3 also serves as a watchdog: if the watchdog is armed when channel 3 matches, the block issues a one-cycle reset request and disarms itself.

Software reaches the registers over a simple 32-bit bus with a select, a write strobe and a word address. Read data and the error flag are registered, so they are valid in the cycle after the access. An access to an offset that is not defined returns zero and flags an error.

Top module: `os_timer`

## Requirements
- R1: After reset, every register reads zero and `irq`, `wdt_reset` and `bus_err` are low.
- R2: Register offsets are as follows. Match values for channels 0 to 3 are at 0x00, 0x04, 0x08 and 0x0C. The counter is at 0x10, the status register at 0x14, the watchdog-enable register at 0x18 and the interrupt-enable register at 0x1C. Read data appears on `bus_rdata` in the cycle after the read is sampled.
- R3: The counter adds one at each clock edge where `tick_en` is high, wraps from 0xFFFFFFFF to 0, and holds its value otherwise.
- R4: A software write to the counter loads the written value and takes precedence over a tick in the same cycle. Matching continues from the loaded value, so loading a value equal to a match value counts as a match.
- R5: Status bit i and `irq[i]` are set at the clock edge where the counter takes the value of match register i, provided interrupt-enable bit i is 1. A counter that holds its value does not match again.
- R6: When interrupt-enable bit i is 0, a match on channel i sets neither status bit i nor `irq[i]`.
- R7: A write to the status register clears each bit 0 to 3 that is written as 1 and leaves the bits written as 0 unchanged. Clearing bit i drops `irq[i]`.
- R8: The interrupt-enable register stores bits 11:0 of the written value. Bits 31:12 read as zero.
- R9: The watchdog is armed by bit 0 of the watchdog-enable register, and only that bit is stored. A channel-3 match while the watchdog is armed raises `wdt_reset` for exactly one cycle and clears the register. This happens whatever the value of interrupt-enable bit 3. With the watchdog unarmed, `wdt_reset` stays low.
- R10: An access is undefined when the address is not a multiple of 4 or is 0x20 or above. Such an access returns zero read data and raises `bus_err` for one cycle. A write to an undefined offset changes no register.
- R11: Each `irq[i]` stays high from the moment it is set until status bit i is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle flag for an undefined access |
| irq | output | 4 | Per-channel interrupt lines for channels 0 to 3 |
| wdt_reset | output | 1 | One-cycle reset request from the watchdog |

## Verification
The counter, the status bits, `irq` and `wdt_reset` all change at the same clock edge that samples the tick or the counter write. Read data and `bus_err` appear one edge after the access is sampled. The bench drives every input at a falling edge and samples at the next falling edge, so each result is read exactly one edge after its cause. The watchdog pulse is checked at the edge before the match, at the match edge and at the edge after it, which confirms that it is present in exactly one cycle.

// File: rtl/os_timer.sv
module os_timer #(
  parameter int AW  = 8,
  parameter int DW  = 32,
  parameter int IEW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  output logic [3:0]    irq,
  output logic          wdt_reset
);
  localparam int NCH = 4;

  logic [DW-1:0]  cnt, cnt_nxt, rmux;
  logic [DW-1:0]  mreg [NCH];
  logic [NCH-1:0] sts, hit, clr;
  logic [IEW-1:0] ier;
  logic           wden, acc_ok, wen, load, upd;
  logic [2:0]     idx;

  assign acc_ok  = (bus_addr[1:0] == 2'b00) && (bus_addr[AW-1:5] == '0);
  assign idx     = bus_addr[4:2];
  assign wen     = bus_sel & bus_wr & acc_ok;
  assign load    = wen && (idx == 3'd4);
  assign upd     = load | tick_en;
  assign cnt_nxt = load ? bus_wdata : (tick_en ? cnt + 1'b1 : cnt);
  assign clr     = (wen && idx == 3'd5) ? bus_wdata[NCH-1:0] : '0;
  assign irq     = sts;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i] = upd && (cnt_nxt == mreg[i]);

    always_ff @(posedge clk) begin
      if (!rst_n)                     mreg[i] <= '0;
      else if (wen && idx == 3'(i))   mreg[i] <= bus_wdata;
    end

    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> $past(ier[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      sts       <= '0;
      ier       <= '0;
      wden      <= 1'b0;
      wdt_reset <= 1'b0;
    end else begin
      cnt       <= cnt_nxt;
      sts       <= (sts & ~clr) | (hit & ier[NCH-1:0]);
      wdt_reset <= hit[3] & wden;
      if (wen && idx == 3'd7) ier <= bus_wdata[IEW-1:0];
      if (hit[3] && wden)                wden <= 1'b0;
      else if (wen && idx == 3'd6)       wden <= bus_wdata[0];
    end
  end

  always_comb begin
    case (idx)
      3'd4:    rmux = cnt;
      3'd5:    rmux = {{(DW-NCH){1'b0}}, sts};
      3'd6:    rmux = {{(DW-1){1'b0}}, wden};
      3'd7:    rmux = {{(DW-IEW){1'b0}}, ier};
      default: rmux = mreg[idx[1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= (bus_sel && !bus_wr && acc_ok) ? rmux : '0;
      bus_err   <= bus_sel & ~acc_ok;
    end
  end

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load) |=> cnt == $past(cnt) + 1'b1);

  assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq) & ~$past(clr) & ~irq) == '0));

  assert_wdt_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset);

  assert_wdt_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> $past(wden));

  assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_rdata == '0);
endmodule

// File: tb/test_os_timer.sv
module test_os_timer;
  logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [3:0]  irq;
  logic        wdt_reset;
  int          errs = 0, checks = 0;
  logic [31:0] d;
  logic        e;

  os_timer i_os_timer (.clk, .rst_n, .tick_en, .bus_sel, .bus_wr, .bus_addr,
                       .bus_wdata, .bus_rdata, .bus_err, .irq, .wdt_reset);

  always #5 clk = ~clk;

  // {address, write value, expected readback}
  localparam logic [95:0] VEC [7] = '{
    {32'h00, 32'h1234_5678, 32'h1234_5678},
    {32'h04, 32'hCAFE_0001, 32'hCAFE_0001},
    {32'h08, 32'h8000_0000, 32'h8000_0000},
    {32'h0C, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
    {32'h10, 32'h0000_ABCD, 32'h0000_ABCD},
    {32'h1C, 32'hFFFF_FFFF, 32'h0000_0FFF},
    {32'h18, 32'hFFFF_FFFF, 32'h0000_0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v, output logic er);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    v = bus_rdata; er = bus_err;
    bus_sel = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errs++;
    $display("FAIL timeout act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq", {28'b0, irq}, 32'h0);
    chk("R1 wdt_reset", {31'b0, wdt_reset}, 32'h0);
    chk("R1 bus_err", {31'b0, bus_err}, 32'h0);
    for (int k = 0; k < 8; k++) begin
      rd(8'(k * 4), d, e);
      chk("R1 register", d, 32'h0);
    end

    // R2 R8 R9 register map walk
    for (int k = 0; k < 7; k++) begin
      wr(VEC[k][71:64], VEC[k][63:32]);
      rd(VEC[k][71:64], d, e);
      chk("R2 readback", d, VEC[k][31:0]);
    end
    wr(8'h18, 32'h0);
    wr(8'h1C, 32'h0);

    // R5 enabled match
    wr(8'h00, 32'd5);
    wr(8'h1C, 32'h1);
    wr(8'h10, 32'd0);
    tick(4);
    chk("R5 before match", {28'b0, irq}, 32'h0);
    tick(1);
    chk("R5 irq on match", {28'b0, irq}, 32'h1);
    rd(8'h14, d, e);
    chk("R5 status", d, 32'h1);

    // R7 write-one-to-clear
    wr(8'h14, 32'h2);
    rd(8'h14, d, e);
    chk("R7 zero bits untouched", d, 32'h1);
    chk("R11 irq held", {28'b0, irq}, 32'h1);
    wr(8'h14, 32'h1);
    chk("R7 irq dropped", {28'b0, irq}, 32'h0);
    rd(8'h14, d, e);
    chk("R7 status cleared", d, 32'h0);
    repeat (3) @(negedge clk);
    chk("R5 no refire on hold", {28'b0, irq}, 32'h0);

    // R4 load equal to match
    wr(8'h10, 32'd5);
    chk("R4 load hits match", {28'b0, irq}, 32'h1);
    wr(8'h14, 32'hF);

    // R6 disabled channel
    wr(8'h04, 32'd3);
    wr(8'h10, 32'd0);
    tick(3);
    chk("R6 irq disabled", {28'b0, irq}, 32'h0);
    rd(8'h14, d, e);
    chk("R6 status disabled", d, 32'h0);

    // R3 wrap
    wr(8'h08, 32'h0);
    wr(8'h1C, 32'h4);
    wr(8'h10, 32'hFFFF_FFFF);
    tick(1);
    chk("R3 wrap match", {28'b0, irq}, 32'h4);
    rd(8'h10, d, e);
    chk("R3 wrapped value", d, 32'h0);
    tick(3);
    rd(8'h10, d, e);
    chk("R3 count", d, 32'h3);
    wr(8'h14, 32'hF);
    wr(8'h1C, 32'h0);

    // R4 write beats tick
    @(negedge clk);
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'd100;
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd(8'h10, d, e);
    chk("R4 write over tick", d, 32'd100);

    // R9 armed watchdog, interrupt for channel 3 disabled
    wr(8'h0C, 32'd10);
    wr(8'h18, 32'h1);
    wr(8'h10, 32'd8);
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    chk("R9 no pulse early", {31'b0, wdt_reset}, 32'h0);
    @(negedge clk);
    chk("R9 pulse on match", {31'b0, wdt_reset}, 32'h1);
    tick_en = 1'b0;
    @(negedge clk);
    chk("R9 pulse one cycle", {31'b0, wdt_reset}, 32'h0);
    chk("R6 irq3 stays low", {28'b0, irq}, 32'h0);
    rd(8'h18, d, e);
    chk("R9 disarmed", d, 32'h0);

    // R9 unarmed watchdog
    wr(8'h10, 32'd8);
    @(negedge clk);
    tick_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 unarmed no pulse", {31'b0, wdt_reset}, 32'h0);
    end
    tick_en = 1'b0;

    // R10 undefined offsets
    rd(8'h20, d, e);
    chk("R10 data zero", d, 32'h0);
    chk("R10 err high", {31'b0, e}, 32'h1);
    @(negedge clk);
    chk("R10 err one cycle", {31'b0, bus_err}, 32'h0);
    rd(8'h02, d, e);
    chk("R10 unaligned err", {31'b0, e}, 32'h1);
    wr(8'h01, 32'hDEAD_BEEF);
    rd(8'h00, d, e);
    chk("R10 write ignored", d, 32'd5);
    chk("R10 defined no err", {31'b0, e}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule